// File: doc/BRIEF.md
# Stereo ADC Peak Level Meter

This block watches the left and right sample streams of a stereo ADC and keeps, for each channel, the loudest level seen since that channel was last read. The level is stored as a 6-bit attenuation code: the number of whole decibels below digital full scale, from 0 (full scale) to 63 (-63 dB or quieter). A register interface reads a channel and pulses that channel's clear input, which begins a new measurement interval for that channel alone.

Each incoming sample is converted to its absolute value and compared in parallel against a bank of 63 thresholds spaced 1 dB apart. The number of thresholds that the magnitude falls below is the attenuation code. The code is merged into the held value, which keeps the smaller (louder) code. Tracking runs only while the enable input is high.

Top module: `adc_peak_meter`

## Requirements
- R1: While rst_n is low and on the first cycle after it rises, both peak_left and peak_right read 63.
- R2: Thresholds are T0 = 2^(SAMPLE_W-1)-1 and Tn = floor(Tn-1 * 58409 / 65536) for n = 1..62. A sample of magnitude M has code equal to the count of n in 0..62 with M < Tn, so M = Tk gives code k, M = Tk-1 gives k+1, and M < T62 (including 0) gives 63.
- R3: Samples are two's complement; the magnitude of a negative sample is its negation, and the most negative value has magnitude 2^(SAMPLE_W-1), which gives code 0.
- R4: A sample accepted on a clock edge updates a channel's held code, visible after that edge, only when its code is smaller than the held code; a sample with an equal or larger code leaves the held code unchanged.
- R5: While peak_en is low, samples have no effect on either held code.
- R6: While smp_valid is low, the sample inputs have no effect on either held code.
- R7: A high clr_left (clr_right) on a clock edge with no accepted sample sets that channel's held code to 63 after the edge and leaves the other channel unchanged.
- R8: When a channel's clear and an accepted sample fall on the same edge, the held code after the edge is the new sample's code, even when it is quieter than the code held before.
- R9: The left sample affects only peak_left and the right sample affects only peak_right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Strobe: both sample inputs carry a new sample |
| smp_left | input | SAMPLE_W | Left channel sample, two's complement |
| smp_right | input | SAMPLE_W | Right channel sample, two's complement |
| peak_en | input | 1 | Enables peak tracking |
| clr_left | input | 1 | Read-clear pulse for the left peak |
| clr_right | input | 1 | Read-clear pulse for the right peak |
| peak_left | output | 6 | Held left attenuation code, dB below full scale |
| peak_right | output | 6 | Held right attenuation code, dB below full scale |

## Verification
The read-clear of a channel and the arrival of a sample for that channel can land on the same clock edge. The bench provokes this by raising clr_right together with an enabled strobe whose right sample is quieter than the held peak, so that a plain minimum would keep the old value; the check demands the new sample's code. A second collision with peak_en low confirms that a clear still wins when the concurrent sample must be ignored.

// File: rtl/peak_meter_pkg.sv
package peak_meter_pkg;

    localparam int CODE_W  = 6;
    localparam int N_STEPS = 1 << CODE_W;
    localparam int N_THR   = N_STEPS - 1;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t QUIET_CODE = code_t'(N_STEPS - 1);

    typedef struct packed {
        code_t left;
        code_t right;
    } peak_pair_t;

    // Merge one channel: clear first, then let an accepted louder sample win.
    function automatic code_t merge_peak(code_t held, logic clr, logic take, code_t fresh);
        code_t base;
        base = clr ? QUIET_CODE : held;
        return (take && (fresh < base)) ? fresh : base;
    endfunction

endpackage

// File: rtl/peak_db_encode.sv
module peak_db_encode
    import peak_meter_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0] sample,
    output code_t               code
);

    localparam longint FULL_SCALE = (longint'(1) << (SAMPLE_W - 1)) - 1;
    localparam longint STEP_NUM   = 58409;  // 10^(-1/20) in Q16

    function automatic longint step_threshold(int n);
        longint t;
        t = FULL_SCALE;
        for (int i = 0; i < n; i++) begin
            t = (t * STEP_NUM) >> 16;
        end
        return t;
    endfunction

    logic [SAMPLE_W-1:0] mag;
    logic [N_THR-1:0]    below;

    assign mag = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;

    for (genvar n = 0; n < N_THR; n++) begin : g_cmp
        localparam logic [SAMPLE_W-1:0] THR = SAMPLE_W'(step_threshold(n));
        assign below[n] = (mag < THR);
    end

    always_comb begin
        code = '0;
        for (int i = 0; i < N_THR; i++) begin
            code = code + code_t'(below[i]);
        end
    end

endmodule

// File: rtl/adc_peak_meter.sv
module adc_peak_meter
    import peak_meter_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                peak_en,
    input  logic                clr_left,
    input  logic                clr_right,
    output logic [5:0]          peak_left,
    output logic [5:0]          peak_right
);

    localparam int N_CH = 2;

    logic [N_CH-1:0][SAMPLE_W-1:0] ch_sample;
    code_t                         ch_code [N_CH];
    logic                          take;
    peak_pair_t                    peak_d, peak_q;

    assign ch_sample[0] = smp_left;
    assign ch_sample[1] = smp_right;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        peak_db_encode #(.SAMPLE_W(SAMPLE_W)) u_enc (
            .sample (ch_sample[c]),
            .code   (ch_code[c])
        );
    end

    assign take = smp_valid & peak_en;

    always_comb begin
        peak_d       = peak_q;
        peak_d.left  = merge_peak(peak_q.left,  clr_left,  take, ch_code[0]);
        peak_d.right = merge_peak(peak_q.right, clr_right, take, ch_code[1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak_q <= '{left: QUIET_CODE, right: QUIET_CODE};
        end else begin
            peak_q <= peak_d;
        end
    end

    assign peak_left  = peak_q.left;
    assign peak_right = peak_q.right;

endmodule

// File: rtl/adc_peak_meter_chk.sv
module adc_peak_meter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_valid,
    input logic       peak_en,
    input logic       clr_left,
    input logic       clr_right,
    input logic [5:0] peak_left,
    input logic [5:0] peak_right
);

    logic take;
    assign take = smp_valid & peak_en;

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (peak_left == 6'd63 && peak_right == 6'd63));

    p_only_louder_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_left |=> (peak_left <= $past(peak_left)));

    p_only_louder_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_right |=> (peak_right <= $past(peak_right)));

    p_idle_hold_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr_left) |=> $stable(peak_left));

    p_idle_hold_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr_right) |=> $stable(peak_right));

    p_clear_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_left && !take) |=> (peak_left == 6'd63));

    p_clear_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_right && !take) |=> (peak_right == 6'd63));

endmodule

bind adc_peak_meter adc_peak_meter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .peak_en    (peak_en),
    .clr_left   (clr_left),
    .clr_right  (clr_right),
    .peak_left  (peak_left),
    .peak_right (peak_right)
);

// File: tb/adc_peak_meter_test.sv
module adc_peak_meter_test;

    localparam int W = 24;

    typedef struct packed {
        int l_k; int l_off; int l_neg;
        int r_k; int r_off; int r_neg;
        int vld; int en; int cl; int cr;
        int exp_l; int exp_r;
    } vec_t;

    // k = 63 means a zero sample; otherwise magnitude T(k)+off
    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{10, 0, 0, 20,  0, 1, 1, 1, 0, 0, 10, 20},  // R2 R3 first capture
        '{12, 0, 0,  5, -1, 0, 1, 1, 0, 0, 10,  6},  // R4 quieter L kept, R2 T5-1 -> 6
        '{ 0, 0, 0,  0,  0, 0, 1, 0, 0, 0, 10,  6},  // R5 disabled
        '{ 0, 0, 0,  0,  0, 0, 0, 1, 0, 0, 10,  6},  // R6 no strobe
        '{ 0, 0, 0,  0,  0, 0, 0, 1, 1, 0, 63,  6},  // R7 clear left only
        '{30, 0, 0, 40,  0, 0, 1, 1, 0, 1, 30, 40},  // R8 clear+quieter sample on right
        '{62,-1, 0, 63,  0, 0, 1, 1, 0, 0, 30, 40},  // R2 below T62 -> 63, zero
        '{ 0, 0, 1, 41,  1, 0, 1, 1, 0, 0,  0, 40},  // R3 -FS -> 0; R4 code 41 > 40
        '{ 0, 0, 0,  0,  0, 0, 0, 1, 1, 1, 63, 63},  // R7 clear both
        '{62, 0, 0, 63,  0, 0, 1, 1, 0, 0, 62, 63},  // R2 T62 -> 62, R9 right unaffected
        '{ 0, 0, 0,  0,  0, 0, 1, 0, 0, 1, 62, 63}   // R5 R8 clear wins, sample ignored
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         smp_valid = 1'b0;
    logic [W-1:0] smp_left = '0;
    logic [W-1:0] smp_right = '0;
    logic         peak_en = 1'b0;
    logic         clr_left = 1'b0;
    logic         clr_right = 1'b0;
    logic [5:0]   peak_left, peak_right;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    adc_peak_meter #(.SAMPLE_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .peak_en(peak_en),
        .clr_left(clr_left), .clr_right(clr_right),
        .peak_left(peak_left), .peak_right(peak_right)
    );

    function automatic longint thr(int k);
        longint t = (longint'(1) << (W - 1)) - 1;
        for (int i = 0; i < k; i++) t = (t * 58409) / 65536;
        return t;
    endfunction

    function automatic logic [W-1:0] mk_sample(int k, int off, int neg);
        longint m = (k >= 63) ? 0 : thr(k) + off;
        if (neg != 0) m = -m;
        return W'(m);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset left", int'(peak_left), 63);
        check("R1 reset right", int'(peak_right), 63);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release left", int'(peak_left), 63);

        for (int i = 0; i < NV; i++) begin
            smp_left  = mk_sample(TBL[i].l_k, TBL[i].l_off, TBL[i].l_neg);
            smp_right = mk_sample(TBL[i].r_k, TBL[i].r_off, TBL[i].r_neg);
            smp_valid = TBL[i].vld[0];
            peak_en   = TBL[i].en[0];
            clr_left  = TBL[i].cl[0];
            clr_right = TBL[i].cr[0];
            step();
            check($sformatf("vec%0d left R2-R9", i), int'(peak_left), TBL[i].exp_l);
            check($sformatf("vec%0d right R2-R9", i), int'(peak_right), TBL[i].exp_r);
        end

        // R3: most negative value reads as full scale
        smp_valid = 1'b1; peak_en = 1'b1; clr_left = 1'b1; clr_right = 1'b0;
        smp_left  = {1'b1, {(W-1){1'b0}}};
        smp_right = '0;
        step();
        check("R3 most negative left", int'(peak_left), 0);
        check("R9 right untouched", int'(peak_right), 63);

        // R2: one below full scale falls to code 1
        clr_left = 1'b1;
        smp_left = W'(thr(0) - 1);
        step();
        check("R2 FS-1 left", int'(peak_left), 1);

        // R1: reset mid-run
        smp_valid = 1'b0; clr_left = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset left", int'(peak_left), 63);
        rst_n = 1'b1;
        step();
        check("R1 mid-run reset right", int'(peak_right), 63);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule